// File: doc/BRIEF.md
# Gated period timer with prescaler

This block is an up-counting timer peripheral with a small word-wide register port. Software writes a control word, a count value and a period value. When it is turned on, the counter advances once per tick of a selectable prescaler. The prescaler is fed by one of three things: every system clock, a synchronized gate level (gated accumulation), or single-cycle pulses taken from the rising edges of an external clock input. When the count reaches the period value, it wraps to zero and raises a sticky event flag. In gated accumulation mode, the end of a gate window also raises that flag.

An interrupt request output is the event flag qualified by an enable bit. It is registered, so it follows the flag and the enable one cycle later. An idle request input can freeze the count when the control word asks for that. Register reads return data one cycle after the address is presented.

Top module: `gptmr_top`

## Requirements
- R1: After reset the count reads 0x0000, the period reads 0xFFFF, the control word reads 0x0000, the interrupt register reads 0 and irq_o is low.
- R2: Register addresses are: 0 control, 1 count, 2 period, 3 interrupt (bit 0 event flag, bit 1 interrupt enable). Control fields are: bit 15 run, bit 13 idle-stop, bit 6 gate mode, bits [5:4] prescale select, bit 2 external sync, bit 1 source (0 internal, 1 external). Every other control bit reads back as zero. bus_rdata shows the register addressed at the previous rising edge.
- R3: With run set and the internal source selected, the count rises by one per prescaler output tick. With run clear, the count holds.
- R4: Prescale select 00, 01, 10 and 11 gives one count step per 1, 8, 64 and 256 input ticks.
- R5: A write to the control or count register while run is set clears the prescaler, and no tick is taken in that cycle. A control write leaves the count untouched. A count write loads the written value.
- R6: When a step occurs while the count equals the period, the count becomes 0x0000 and the event flag is set.
- R7: The event flag stays set until a write to address 3 with bit 0 low. irq_o equals flag AND enable, delayed by one cycle.
- R8: With gate mode set and the internal source selected, the count advances only while the synchronized gate input is high.
- R9: In gate mode, a falling edge of the synchronized gate sets the event flag. Outside gate mode, a gate fall does not set it.
- R10: With the external source selected, each rising edge of ext_clk_in gives one input tick. With sync = 1 the edge goes through a two-flop synchronizer. With sync = 0 it goes through one sampling flop.
- R11: While idle_req is high and idle-stop is set, the count holds and then resumes from the held value. With idle-stop clear, idle_req has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Registered read data |
| gate_in | input | 1 | Asynchronous gate input for accumulation mode |
| ext_clk_in | input | 1 | Asynchronous external count clock |
| idle_req | input | 1 | Idle request from the processor |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its default parameters: a 16-bit count, an 8-bit prescaler and two synchronizer stages. At these values every prescale ratio up to 1:256 can be exercised in a few thousand cycles. Writing a small period value brings the wrap and the flag within a few tens of cycles. Each timing scenario ends by clearing run, so the count that is read back is an exact function of the cycles, edges and gate windows applied. This also shows whether a prescaler clear dropped or kept the tick in the same cycle.

// File: rtl/gptmr_pkg.sv
package gptmr_pkg;

  localparam int CTRL_W     = 16;
  localparam int B_RUN      = 15;
  localparam int B_IDLESTOP = 13;
  localparam int B_GATE     = 6;
  localparam int B_PS_LO    = 4;
  localparam int B_SYNC     = 2;
  localparam int B_SRC      = 1;
  localparam logic [CTRL_W-1:0] CTRL_MASK = 16'hA076;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_COUNT  = 2'd1,
    REG_PERIOD = 2'd2,
    REG_IRQ    = 2'd3
  } reg_sel_e;

  // log2 of the division ratio for each prescale code
  function automatic int unsigned ps_shift(input logic [1:0] sel);
    case (sel)
      2'b00:   return 0;
      2'b01:   return 3;
      2'b10:   return 6;
      default: return 8;
    endcase
  endfunction

endpackage

// File: rtl/gptmr_sync_edge.sv
module gptmr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall,
  output logic early_rise
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst) pipe_q <= '0;
    else     pipe_q <= {pipe_q[DEPTH-2:0], din};
  end

  assign lvl        = pipe_q[STAGES-1];
  assign rise       = pipe_q[STAGES-1] & ~pipe_q[STAGES];
  assign fall       = ~pipe_q[STAGES-1] & pipe_q[STAGES];
  // edge seen after a single sampling flop (source already synchronous)
  assign early_rise = pipe_q[0] & ~pipe_q[1];

endmodule

// File: rtl/gptmr_prescaler.sv
module gptmr_prescaler #(
  parameter int PS_W = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       tick_in,
  input  logic [1:0] sel,
  output logic       tick_out
);
  import gptmr_pkg::*;

  logic [PS_W-1:0] pcnt_q;
  logic [PS_W-1:0] term;
  logic            at_term;

  assign term     = PS_W'((32'd1 << ps_shift(sel)) - 32'd1);
  assign at_term  = (pcnt_q >= term);
  assign tick_out = tick_in & at_term & ~clr;

  always_ff @(posedge clk) begin
    if (rst)          pcnt_q <= '0;
    else if (clr)     pcnt_q <= '0;
    else if (tick_in) pcnt_q <= at_term ? '0 : pcnt_q + 1'b1;
  end

endmodule

// File: rtl/gptmr_top.sv
module gptmr_top #(
  parameter int CNT_W       = 16,
  parameter int PS_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic             gate_in,
  input  logic             ext_clk_in,
  input  logic             idle_req,
  output logic             irq_o
);
  import gptmr_pkg::*;

  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  cnt_q, prd_q;
  logic              flag_q, ien_q, irq_q;

  // register decode
  logic wr_ctrl, wr_cnt, wr_prd, wr_irq;
  assign wr_ctrl = bus_we && (bus_addr == REG_CTRL);
  assign wr_cnt  = bus_we && (bus_addr == REG_COUNT);
  assign wr_prd  = bus_we && (bus_addr == REG_PERIOD);
  assign wr_irq  = bus_we && (bus_addr == REG_IRQ);

  // control fields
  logic ctrl_on, idle_stop, gate_mode, ext_sync, src_ext;
  logic [1:0] ps_sel;
  assign ctrl_on   = ctrl_q[B_RUN];
  assign idle_stop = ctrl_q[B_IDLESTOP];
  assign gate_mode = ctrl_q[B_GATE];
  assign ps_sel    = ctrl_q[B_PS_LO+1:B_PS_LO];
  assign ext_sync  = ctrl_q[B_SYNC];
  assign src_ext   = ctrl_q[B_SRC];

  // input conditioning
  logic gate_lvl, gate_fall, unused_gate_rise, unused_gate_early;
  logic ext_rise, ext_early, unused_ext_lvl, unused_ext_fall;

  gptmr_sync_edge #(.STAGES(SYNC_STAGES)) u_gate_sync (
    .clk(clk), .rst(rst), .din(gate_in),
    .lvl(gate_lvl), .rise(unused_gate_rise), .fall(gate_fall),
    .early_rise(unused_gate_early)
  );

  gptmr_sync_edge #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk(clk), .rst(rst), .din(ext_clk_in),
    .lvl(unused_ext_lvl), .rise(ext_rise), .fall(unused_ext_fall),
    .early_rise(ext_early)
  );

  // tick source selection
  logic gated, held, ext_pulse, raw_tick, ps_clr, step;
  assign gated     = gate_mode & ~src_ext;
  assign held      = idle_req & idle_stop;
  assign ext_pulse = ext_sync ? ext_rise : ext_early;
  assign raw_tick  = ctrl_on & ~held &
                     (src_ext ? ext_pulse : (gated ? gate_lvl : 1'b1));
  assign ps_clr    = ctrl_on & (wr_ctrl | wr_cnt);

  gptmr_prescaler #(.PS_W(PS_W)) u_ps (
    .clk(clk), .rst(rst), .clr(ps_clr), .tick_in(raw_tick),
    .sel(ps_sel), .tick_out(step)
  );

  // counter and events
  logic match_evt, gate_evt, set_evt;
  assign match_evt = step & (cnt_q == prd_q) & ~wr_cnt;
  assign gate_evt  = ctrl_on & gated & gate_fall;
  assign set_evt   = match_evt | gate_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      cnt_q  <= '0;
      prd_q  <= '1;
      flag_q <= 1'b0;
      ien_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0] & CTRL_MASK;
      if (wr_prd)  prd_q  <= bus_wdata;
      if (wr_cnt)            cnt_q <= bus_wdata;
      else if (match_evt)    cnt_q <= '0;
      else if (step)         cnt_q <= cnt_q + 1'b1;
      if (wr_irq) begin
        flag_q <= bus_wdata[0] | set_evt;
        ien_q  <= bus_wdata[1];
      end else if (set_evt) begin
        flag_q <= 1'b1;
      end
      irq_q <= flag_q & ien_q;
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      case (bus_addr)
        REG_CTRL:   bus_rdata <= CNT_W'(ctrl_q);
        REG_COUNT:  bus_rdata <= cnt_q;
        REG_PERIOD: bus_rdata <= prd_q;
        default:    bus_rdata <= CNT_W'({ien_q, flag_q});
      endcase
    end
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/gptmr_chk.sv
module gptmr_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             ctrl_on,
  input logic             idle_stop,
  input logic             idle_req,
  input logic             gated,
  input logic             gate_lvl,
  input logic             wr_cnt,
  input logic             wr_irq,
  input logic [CNT_W-1:0] cnt_q,
  input logic             flag_q
);

  // R3
  hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_on && !wr_cnt) |=> $stable(cnt_q));

  // R11
  idle_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_on && idle_req && idle_stop && !wr_cnt) |=> $stable(cnt_q));

  // R8
  gate_low_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_on && gated && !gate_lvl && !wr_cnt) |=> $stable(cnt_q));

  // R6
  step_or_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_cnt) |=> (cnt_q == $past(cnt_q) ||
                   cnt_q == CNT_W'($past(cnt_q) + 1'b1) ||
                   (cnt_q == '0 && flag_q)));

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !wr_irq) |=> flag_q);

endmodule

bind gptmr_top gptmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .ctrl_on(ctrl_on), .idle_stop(idle_stop),
  .idle_req(idle_req), .gated(gated), .gate_lvl(gate_lvl),
  .wr_cnt(wr_cnt), .wr_irq(wr_irq), .cnt_q(cnt_q), .flag_q(flag_q)
);

// File: tb/gptmr_top_tb_top.sv
`timescale 1ns/1ps
module gptmr_top_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        gate_in = 1'b0;
  logic        ext_clk_in = 1'b0;
  logic        idle_req = 1'b0;
  logic        irq_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  gptmr_top dut_i (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gate_in(gate_in),
    .ext_clk_in(ext_clk_in), .idle_req(idle_req), .irq_o(irq_o)
  );

  // scoreboard
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        rd_strobe = 1'b0;
  logic        rd_seen = 1'b0;

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= rd_strobe;

  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  // all tasks start and end at a falling edge
  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [15:0] exp, string tag);
    bus_addr = a; rd_strobe = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; cyc(3); rst = 1'b0; cyc(1);
  endtask

  // enable with ctrl, let n cycles pass, then stop
  task automatic run(logic [15:0] ctrl, int n);
    wr(2'd0, ctrl); cyc(n); wr(2'd0, 16'h0000);
  endtask

  task automatic ext_pulses(int n);
    for (int i = 0; i < n; i++) begin
      ext_clk_in = 1'b1; cyc(2); ext_clk_in = 1'b0; cyc(2);
    end
    cyc(5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    cyc(4); rst = 1'b0; cyc(1);
    // R1 reset state
    rd(2'd0, 16'h0000, "R1 ctrl");
    rd(2'd1, 16'h0000, "R1 count");
    rd(2'd2, 16'hFFFF, "R1 period");
    rd(2'd3, 16'h0000, "R1 irq reg");
    check("R1 irq_o", {15'd0, irq_o}, 16'h0000);

    // R2 readback masking and map
    wr(2'd0, 16'hFFFF);
    rd(2'd0, 16'hA076, "R2 ctrl mask");
    wr(2'd0, 16'h0000);
    wr(2'd2, 16'h1234);
    rd(2'd2, 16'h1234, "R2 period");
    wr(2'd1, 16'h0042);
    rd(2'd1, 16'h0042, "R2 count");

    // R3 internal 1:1, then hold when off
    do_reset();
    run(16'h8000, 37);
    rd(2'd1, 16'd37, "R3 count 1:1");
    cyc(10);
    rd(2'd1, 16'd37, "R3 hold off");

    // R4 each prescale ratio, ten steps
    for (int s = 0; s < 4; s++) begin
      int ratio;
      ratio = (s == 0) ? 1 : (s == 1) ? 8 : (s == 2) ? 64 : 256;
      do_reset();
      run(16'h8000 | 16'(s << 4), 10 * ratio);
      rd(2'd1, 16'd10, "R4 prescale");
    end

    // R5 control write clears prescaler, keeps count
    do_reset();
    wr(2'd0, 16'h8010); cyc(19);
    wr(2'd0, 16'h8010); cyc(5);
    wr(2'd0, 16'h0000);
    rd(2'd1, 16'd2, "R5 ctrl write");
    // R5 count write loads and clears prescaler
    do_reset();
    wr(2'd0, 16'h8010); cyc(19);
    wr(2'd1, 16'd100); cyc(5);
    wr(2'd0, 16'h0000);
    rd(2'd1, 16'd100, "R5 count write");

    // R6 period wrap and flag, R7 irq gating and clear
    do_reset();
    wr(2'd2, 16'd9);
    run(16'h8000, 25);
    rd(2'd1, 16'd5, "R6 wrap count");
    cyc(20);
    rd(2'd3, 16'h0001, "R6 R7 flag sticky");
    check("R7 irq masked", {15'd0, irq_o}, 16'h0000);
    wr(2'd3, 16'h0003); cyc(2);
    check("R7 irq raised", {15'd0, irq_o}, 16'h0001);
    wr(2'd3, 16'h0002); cyc(2);
    rd(2'd3, 16'h0002, "R7 flag cleared");
    check("R7 irq dropped", {15'd0, irq_o}, 16'h0000);

    // R8 R9 gated accumulation
    do_reset();
    wr(2'd0, 16'h8040); cyc(3);
    gate_in = 1'b1; cyc(13); gate_in = 1'b0; cyc(6);
    wr(2'd0, 16'h0000);
    rd(2'd1, 16'd13, "R8 gated count");
    rd(2'd3, 16'h0001, "R9 gate fall flag");
    do_reset();
    wr(2'd0, 16'h0000); cyc(2);
    gate_in = 1'b1; cyc(5); gate_in = 1'b0; cyc(6);
    wr(2'd0, 16'h8000); cyc(4); wr(2'd0, 16'h0000);
    rd(2'd3, 16'h0000, "R9 no flag outside gate mode");

    // R10 external clock, sync and direct, with prescale
    do_reset();
    wr(2'd0, 16'h8006); ext_pulses(9); wr(2'd0, 16'h0000);
    rd(2'd1, 16'd9, "R10 ext sync");
    do_reset();
    wr(2'd0, 16'h8002); ext_pulses(5); wr(2'd0, 16'h0000);
    rd(2'd1, 16'd5, "R10 ext direct");
    do_reset();
    wr(2'd0, 16'h8016); ext_pulses(16); wr(2'd0, 16'h0000);
    rd(2'd1, 16'd2, "R10 ext 1:8");

    // R11 idle stop
    do_reset();
    wr(2'd0, 16'hA000); cyc(5);
    idle_req = 1'b1; cyc(10); idle_req = 1'b0; cyc(5);
    wr(2'd0, 16'h0000);
    rd(2'd1, 16'd10, "R11 idle freeze");
    do_reset();
    wr(2'd0, 16'h8000); cyc(5);
    idle_req = 1'b1; cyc(10); idle_req = 1'b0; cyc(5);
    wr(2'd0, 16'h0000);
    rd(2'd1, 16'd20, "R11 idle ignored");

    cyc(3);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule